// File: doc/BRIEF.md
# Half-Bridge Gate Command Logic

This block sits between the digital controller of a half-bridge power stage and the two gate drivers. It takes a low-side command, a high-side command and an active-low shutdown, together with qualified "supply good" flags for the logic supply and for the floating bootstrap supply and a thermal-fault flag. From these it produces the final low-side and high-side gate enables. Both switches must never conduct together, and neither may be switched with a supply that is too low.

Each of the six inputs passes through a two-stage synchronizer. The two commands then pass through a minimum-pulse filter, so that a command level shorter than `MIN_W` clock cycles never reaches a gate. The combined enable applies shutdown, thermal fault and logic-supply lockout to both sides. Cross-conduction interlock and bootstrap lockout are applied as well. After a bootstrap lockout, a re-arm latch keeps the high side off until the high-side command shows a new rising edge. Both outputs are registered.

Top module: `hb_gate_ctrl`

## Requirements
- R1: After reset, and while both commands are low (idle), both gate outputs are 0.
- R2: With shutdown high (1 = run), no fault and both supplies good, a lone high command drives only its own side to 1. A command change appears at the output `MIN_W`+3 clock edges after it is applied.
- R3: When both commands are 1 at once, both outputs are 0.
- R4: When the shutdown input is 0, both outputs are 0 within 3 edges. They follow the commands again 3 edges after it returns to 1.
- R5: When the thermal-fault input is 1 (1 = fault), both outputs are 0 within 3 edges. They resume 3 edges after it clears.
- R6: When the logic-supply flag is 0 (1 = good), both outputs are 0. When the flag returns to 1, the outputs follow the commands again after 3 edges, and no new command edge is needed.
- R7: When the bootstrap-supply flag is 0 (1 = good), the high output goes to 0 within 3 edges. The low output is unaffected.
- R8: After the bootstrap flag returns to 1, the high output stays 0 while the high command is held. It turns on `MIN_W`+3 edges after a fresh 0-to-1 transition of the high command.
- R9: A command level held for fewer than `MIN_W` cycles has no effect at the output. A level held for exactly `MIN_W` cycles passes, and the output pulse is `MIN_W` cycles wide.
- R10: The two outputs are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sd_n_i | input | 1 | Shutdown, 0 = both sides off |
| lo_cmd_i | input | 1 | Low-side command, 1 = on |
| hi_cmd_i | input | 1 | High-side command, 1 = on |
| vlog_ok_i | input | 1 | Logic supply good, 1 = good |
| vboot_ok_i | input | 1 | Bootstrap supply good, 1 = good |
| therm_flt_i | input | 1 | Thermal fault, 1 = fault |
| lo_gate_o | output | 1 | Low-side gate enable |
| hi_gate_o | output | 1 | High-side gate enable |

## Verification
Command changes travel through two synchronizer stages, `MIN_W` filter edges and the output register, so they are due `MIN_W`+3 edges after being driven. Shutdown, thermal and supply flags skip the filter and are due after 3 edges. The bench drives inputs just after a falling edge, counts exactly that many rising edges, and samples at the following falling edge. For the latency claims it also samples one edge early to confirm the old value still holds. Pulse-width cases are checked by counting output-high cycles over a fixed window rather than at a single instant.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  // bit positions inside the synchronized input vector
  localparam int IDX_LO    = 0;
  localparam int IDX_HI    = 1;
  localparam int IDX_SD    = 2;
  localparam int IDX_THERM = 3;
  localparam int IDX_VLOG  = 4;
  localparam int IDX_VBOOT = 5;
  localparam int NSIG      = 6;
  localparam int NCMD      = 2;
  // safe values while the synchronizer is in reset: commands off,
  // shutdown asserted, fault asserted, supplies reported bad
  localparam logic [NSIG-1:0] SYNC_SAFE = 6'b001000;
endpackage

// File: rtl/hbg_rst_sync.sv
module hbg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_q_n = stg_q[1];
endmodule

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= RST_VAL;
    else        stg_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/hbg_pulse_filter.sv
module hbg_pulse_filter #(
  parameter int MIN_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(MIN_W - 1);

  logic          q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en, differ;

  always_comb begin
    differ = din ^ q_q;
    q_d    = q_q;
    cnt_d  = '0;
    if (differ) begin
      if (cnt_q == CNT_LAST) begin
        q_d   = din;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    cnt_en = differ | (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      q_q <= q_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign dout = q_q;
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int MIN_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sd_n_i,
  input  logic lo_cmd_i,
  input  logic hi_cmd_i,
  input  logic vlog_ok_i,
  input  logic vboot_ok_i,
  input  logic therm_flt_i,
  output logic lo_gate_o,
  output logic hi_gate_o
);
  logic            rst_q_n;
  logic [NSIG-1:0] raw_v, sync_v;
  logic [NCMD-1:0] cmd_f;
  logic            lo_f, hi_f, hi_s;
  logic            sd_s, therm_s, vlog_s, vboot_s;
  logic            hi_f_q;
  logic            rearm_blk, rearm_blk_d, blk_en;
  logic            hi_rise, drv_en, hi_ok;
  logic            lo_gate_d, hi_gate_d;

  hbg_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    raw_v            = '0;
    raw_v[IDX_LO]    = lo_cmd_i;
    raw_v[IDX_HI]    = hi_cmd_i;
    raw_v[IDX_SD]    = sd_n_i;
    raw_v[IDX_THERM] = therm_flt_i;
    raw_v[IDX_VLOG]  = vlog_ok_i;
    raw_v[IDX_VBOOT] = vboot_ok_i;
  end

  hbg_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_SAFE)) u_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .din   (raw_v),
    .dout  (sync_v)
  );

  for (genvar i = 0; i < NCMD; i++) begin : g_flt
    hbg_pulse_filter #(.MIN_W(MIN_W)) u_flt (
      .clk   (clk),
      .rst_n (rst_q_n),
      .din   (sync_v[i]),
      .dout  (cmd_f[i])
    );
  end

  assign lo_f    = cmd_f[IDX_LO];
  assign hi_f    = cmd_f[IDX_HI];
  assign hi_s    = sync_v[IDX_HI];
  assign sd_s    = sync_v[IDX_SD];
  assign therm_s = sync_v[IDX_THERM];
  assign vlog_s  = sync_v[IDX_VLOG];
  assign vboot_s = sync_v[IDX_VBOOT];

  // next-state logic
  always_comb begin
    hi_rise     = hi_f & ~hi_f_q;
    drv_en      = sd_s & ~therm_s & vlog_s;
    rearm_blk_d = rearm_blk;
    if (!vboot_s)     rearm_blk_d = 1'b1;
    else if (hi_rise) rearm_blk_d = 1'b0;
    blk_en      = rearm_blk_d ^ rearm_blk;
    hi_ok       = ~rearm_blk | hi_rise;
    lo_gate_d   = drv_en & lo_f & ~hi_f;
    hi_gate_d   = drv_en & hi_f & ~lo_f & vboot_s & hi_ok;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      hi_f_q    <= 1'b0;
      rearm_blk <= 1'b0;
      lo_gate_o <= 1'b0;
      hi_gate_o <= 1'b0;
    end else begin
      hi_f_q    <= hi_f;
      if (blk_en) rearm_blk <= rearm_blk_d;
      lo_gate_o <= lo_gate_d;
      hi_gate_o <= hi_gate_d;
    end
  end
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker (
  input logic clk,
  input logic rst_q_n,
  input logic sd_s,
  input logic therm_s,
  input logic vlog_s,
  input logic vboot_s,
  input logic lo_f,
  input logic hi_f,
  input logic hi_s,
  input logic rearm_blk,
  input logic hi_rise,
  input logic lo_gate_o,
  input logic hi_gate_o
);
  assert_never_both_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(lo_gate_o && hi_gate_o));

  assert_interlock_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (lo_f && hi_f) |=> (!lo_gate_o && !hi_gate_o));

  assert_shutdown_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !sd_s |=> (!lo_gate_o && !hi_gate_o));

  assert_thermal_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    therm_s |=> (!lo_gate_o && !hi_gate_o));

  assert_logic_uv_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !vlog_s |=> (!lo_gate_o && !hi_gate_o));

  assert_boot_uv_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !vboot_s |=> !hi_gate_o);

  assert_rearm_hold_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rearm_blk && !hi_rise) |=> !hi_gate_o);

  assert_filter_follow_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !$stable(hi_f) |-> (hi_f == $past(hi_s)));
endmodule

bind hb_gate_ctrl hbg_checker u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .sd_s      (sd_s),
  .therm_s   (therm_s),
  .vlog_s    (vlog_s),
  .vboot_s   (vboot_s),
  .lo_f      (lo_f),
  .hi_f      (hi_f),
  .hi_s      (hi_s),
  .rearm_blk (rearm_blk),
  .hi_rise   (hi_rise),
  .lo_gate_o (lo_gate_o),
  .hi_gate_o (hi_gate_o)
);

// File: tb/hb_gate_ctrl_bench.sv
`timescale 1ns/1ps
module hb_gate_ctrl_bench;
  localparam int MIN_W = 6;
  localparam int SYNC  = 2;
  localparam int LCMD  = MIN_W + SYNC + 1; // command to output
  localparam int LFLG  = SYNC + 1;         // flag to output

  logic clk = 1'b0;
  logic rst_n, sd_n, lo_cmd, hi_cmd, vlog_ok, vboot_ok, therm;
  logic lo_gate, hi_gate;
  int   checks = 0, errs = 0, both_err = 0;
  bit   done = 1'b0, live = 1'b0;

  always #10 clk = ~clk;

  hb_gate_ctrl #(.MIN_W(MIN_W), .SYNC_STAGES(SYNC)) u_hb_gate_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sd_n_i      (sd_n),
    .lo_cmd_i    (lo_cmd),
    .hi_cmd_i    (hi_cmd),
    .vlog_ok_i   (vlog_ok),
    .vboot_ok_i  (vboot_ok),
    .therm_flt_i (therm),
    .lo_gate_o   (lo_gate),
    .hi_gate_o   (hi_gate)
  );

  // R10 monitor: both on in the same cycle
  always @(negedge clk) if (live && lo_gate && hi_gate) both_err++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic gates(string req, int lo_e, int hi_e);
    chk({req, " low"}, int'(lo_gate), lo_e);
    chk({req, " high"}, int'(hi_gate), hi_e);
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_R1();
    rst_n = 1'b0; sd_n = 1'b1; lo_cmd = 1'b0; hi_cmd = 1'b0;
    vlog_ok = 1'b1; vboot_ok = 1'b1; therm = 1'b0;
    edges(5);
    rst_n = 1'b1;
    edges(10);
    live = 1'b1;
    gates("R1 after reset", 0, 0);
    edges(20);
    gates("R1 idle commands", 0, 0);
  endtask

  task automatic t_truth_R2();
    lo_cmd = 1'b1;
    edges(LCMD - 1);
    gates("R2 low not yet", 0, 0);
    edges(1);
    gates("R2 low alone", 1, 0);
    lo_cmd = 1'b0; edges(LCMD);
    gates("R2 both low", 0, 0);
    hi_cmd = 1'b1; edges(LCMD);
    gates("R2 high alone", 0, 1);
    hi_cmd = 1'b0; edges(LCMD);
    gates("R2 high released", 0, 0);
  endtask

  task automatic t_interlock_R3();
    lo_cmd = 1'b1; edges(LCMD);
    gates("R3 low first", 1, 0);
    hi_cmd = 1'b1; edges(LCMD);
    gates("R3 both commands", 0, 0);
    lo_cmd = 1'b0; edges(LCMD);
    gates("R3 low dropped", 0, 1);
    hi_cmd = 1'b0; edges(LCMD);
  endtask

  task automatic t_shutdown_R4();
    lo_cmd = 1'b1; edges(LCMD);
    sd_n = 1'b0; edges(LFLG);
    gates("R4 shutdown", 0, 0);
    sd_n = 1'b1; edges(LFLG);
    gates("R4 shutdown released", 1, 0);
    lo_cmd = 1'b0; edges(LCMD);
  endtask

  task automatic t_thermal_R5();
    hi_cmd = 1'b1; edges(LCMD);
    gates("R5 before fault", 0, 1);
    therm = 1'b1; edges(LFLG);
    gates("R5 fault", 0, 0);
    therm = 1'b0; edges(LFLG);
    gates("R5 fault cleared", 0, 1);
    hi_cmd = 1'b0; edges(LCMD);
  endtask

  task automatic t_logic_uv_R6();
    hi_cmd = 1'b1; edges(LCMD);
    vlog_ok = 1'b0; edges(LFLG);
    gates("R6 logic uv", 0, 0);
    vlog_ok = 1'b1; edges(LFLG);
    gates("R6 logic recovered", 0, 1);
    hi_cmd = 1'b0; edges(LCMD);
  endtask

  task automatic t_boot_uv_R7();
    lo_cmd = 1'b1; edges(LCMD);
    vboot_ok = 1'b0; edges(LFLG);
    gates("R7 boot uv low kept", 1, 0);
    edges(10);
    gates("R7 boot uv low still", 1, 0);
    vboot_ok = 1'b1; edges(LFLG);
    gates("R7 boot back low", 1, 0);
    lo_cmd = 1'b0; edges(LCMD);
    hi_cmd = 1'b1; edges(LCMD);
    gates("R7 high armed", 0, 1);
    vboot_ok = 1'b0; edges(LFLG);
    gates("R7 boot uv high off", 0, 0);
  endtask

  task automatic t_rearm_R8();
    // high command still held from previous task, bootstrap low
    vboot_ok = 1'b1; edges(LFLG);
    gates("R8 held after recovery", 0, 0);
    edges(20);
    gates("R8 still held", 0, 0);
    hi_cmd = 1'b0; edges(LCMD);
    hi_cmd = 1'b1; edges(LCMD - 1);
    gates("R8 rise not yet", 0, 0);
    edges(1);
    gates("R8 fresh rise", 0, 1);
    hi_cmd = 1'b0; edges(LCMD);
  endtask

  task automatic pulse_count(bit on_lo, bit base, int width, output int ones);
    ones = 0;
    if (on_lo) lo_cmd = ~base; else hi_cmd = ~base;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (c == width - 1) begin
        if (on_lo) lo_cmd = base; else hi_cmd = base;
      end
      ones += on_lo ? int'(lo_gate) : int'(hi_gate);
    end
  endtask

  task automatic t_filter_R9();
    int n;
    pulse_count(1'b1, 1'b0, MIN_W - 1, n);
    chk("R9 short low-side pulse dropped", n, 0);
    pulse_count(1'b1, 1'b0, MIN_W, n);
    chk("R9 minimum low-side pulse width", n, MIN_W);
    pulse_count(1'b0, 1'b0, MIN_W - 1, n);
    chk("R9 short high-side pulse dropped", n, 0);
    hi_cmd = 1'b1; edges(LCMD);
    pulse_count(1'b0, 1'b1, MIN_W - 1, n);
    chk("R9 short dip ignored", n, 40);
    hi_cmd = 1'b0; edges(LCMD);
  endtask

  initial begin
    t_reset_R1();
    t_truth_R2();
    t_interlock_R3();
    t_shutdown_R4();
    t_thermal_R5();
    t_logic_uv_R6();
    t_boot_uv_R7();
    t_rearm_R8();
    t_filter_R9();
    chk("R10 never both on", both_err, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule